// File: doc/BRIEF.md
# Supply-Fail Memory Access Guard

This block sits between a memory controller and a battery-backed static memory. It watches a digital "supply good" level from an external voltage comparator. When the supply fails, it closes the path for the memory strobes. When the supply comes back, it reopens that path in steps: reads come back first and writes come back last.

The supply level is asynchronous, so it passes through a two-stage synchronizer first. The block then runs a three-state sequencer: protected, recovering and normal.

- **Protected:** every request from the controller is ignored. The strobes are held inactive and the data drive enable stays off.
- **Recovering:** starts when the supply turns good. Writes stay blocked for a programmable recovery interval. Chip enable, and with it reads, stays blocked only for a shorter programmable hold-off at the start of the recovery. If the supply drops during recovery, the sequencer returns to protected, and the next recovery starts its timing from zero.
- **Normal:** requests pass straight through to the memory.

A sticky flag records that a good supply has been seen at least once since reset. A higher level uses this flag to enable battery backup.

The two interval parameters are sized in clock cycles. At 250 MHz, the defaults give 125 ms of write protection and 2 ms of strobe hold-off. A bench can set them much shorter.

Top module: `supply_guard`

## Requirements
- R1: While `rst_ni` is low, `ce_o`, `we_o` and `oe_o` are 0, `wp_o` is 1 and `armed_o` is 0, whatever the other inputs are.
- R2: `supply_ok_i` is sampled through two flops. If `supply_ok_i` is 0 at a rising clock edge, then `ce_o` and `we_o` are 0 after the third rising edge that follows it, at the latest.
- R3: In the protected state, `ce_i`, `we_i` and `oe_i` have no effect: `ce_o`, `we_o` and `oe_o` all stay 0.
- R4: `wp_o` is 1, and `we_o` is 0, from the moment the supply drops until RECOVER_CYC cycles after the synchronized supply has been continuously good. Counting starts from the first edge at which the sequencer leaves the protected state.
- R5: During recovery, `ce_o` is 0 for the first HOLD_CYC cycles. For the rest of the recovery, `ce_o` follows `ce_i`. HOLD_CYC must be below RECOVER_CYC.
- R6: If the synchronized supply drops during recovery, the block returns to the protected state. The next recovery times both intervals again from zero.
- R7: In the normal state, `ce_o` = `ce_i` and `we_o` = `we_i` & `ce_i`. `oe_o` = `ce_o` & `oe_i` & ~`we_i`, in every state, so a write request always turns the data drive off.
- R8: `armed_o` turns to 1 when the sequencer first leaves the protected state. It then stays 1 through later supply failures until reset. `wp_o` is never 0 while `armed_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| supply_ok_i | input | 1 | Asynchronous supply-good level from the comparator |
| ce_i | input | 1 | Chip enable request from the controller, active high |
| we_i | input | 1 | Write enable request, active high |
| oe_i | input | 1 | Output enable request, active high |
| ce_o | output | 1 | Gated chip enable to the memory, active high |
| we_o | output | 1 | Gated write enable to the memory, active high |
| oe_o | output | 1 | Data drive enable; 0 means the outputs float |
| wp_o | output | 1 | Write protection active |
| armed_o | output | 1 | Backup armed: a good supply has been seen since reset |

## Verification
The bench runs a short configuration. On every cycle it steps through all eight combinations of the three request inputs, so each strobe gating rule is tried against every request pattern in each state.

The supply follows a fixed schedule:
- a long good interval, which shows the read hold-off, the write hold-off and normal pass-through as separate phases;
- a drop in the middle of recovery, which tells a restarted timer from one that resumes;
- a single-cycle dip, which checks that one sampled low level is enough to force protection.

The armed flag is checked before the first good supply and across every later outage.

// File: rtl/supply_guard_pkg.sv
package supply_guard_pkg;

    typedef enum logic [1:0] {
        SG_PROTECT = 2'd0,
        SG_RECOVER = 2'd1,
        SG_NORMAL  = 2'd2
    } sg_state_e;

endpackage

// File: rtl/supply_guard_sync.sv
module supply_guard_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = async_i;
        end else begin : g_many
            always_comb chain_d = {chain_q[LAST-1:0], async_i};
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign sync_o = chain_q[LAST];
endmodule

// File: rtl/supply_guard_gate.sv
module supply_guard_gate (
    input  logic rd_allow_i,
    input  logic wr_allow_i,
    input  logic ce_i,
    input  logic we_i,
    input  logic oe_i,
    output logic ce_o,
    output logic we_o,
    output logic oe_o
);
    always_comb begin
        ce_o = ce_i & rd_allow_i;
        we_o = we_i & ce_i & wr_allow_i;
        // a pending write always releases the data bus
        oe_o = ce_o & oe_i & ~we_i;
    end
endmodule

// File: rtl/supply_guard.sv
module supply_guard
    import supply_guard_pkg::*;
#(
    parameter int RECOVER_CYC = 31_250_000,
    parameter int HOLD_CYC    = 500_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic supply_ok_i,
    input  logic ce_i,
    input  logic we_i,
    input  logic oe_i,
    output logic ce_o,
    output logic we_o,
    output logic oe_o,
    output logic wp_o,
    output logic armed_o
);
    localparam int CW = $clog2(RECOVER_CYC + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(RECOVER_CYC - 1);
    localparam logic [CW-1:0] CNT_HOLD = CW'(HOLD_CYC);

    typedef struct packed {
        sg_state_e     st;
        logic [CW-1:0] cnt;
        logic          armed;
    } regs_t;

    regs_t r_d, r_q;
    logic  ok_s;
    logic  rd_allow, wr_allow;

    supply_guard_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i(supply_ok_i),
        .sync_o (ok_s)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            SG_PROTECT: begin
                r_d.cnt = '0;
                if (ok_s) begin
                    r_d.st    = SG_RECOVER;
                    r_d.armed = 1'b1;
                end
            end
            SG_RECOVER: begin
                if (!ok_s) begin
                    r_d.st  = SG_PROTECT;
                    r_d.cnt = '0;
                end else if (r_q.cnt == CNT_LAST) begin
                    r_d.st = SG_NORMAL;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            SG_NORMAL: begin
                if (!ok_s) begin
                    r_d.st  = SG_PROTECT;
                    r_d.cnt = '0;
                end
            end
            default: begin
                r_d.st  = SG_PROTECT;
                r_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.st    <= SG_PROTECT;
            r_q.cnt   <= '0;
            r_q.armed <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        wr_allow = (r_q.st == SG_NORMAL);
        rd_allow = wr_allow || ((r_q.st == SG_RECOVER) && (r_q.cnt >= CNT_HOLD));
    end

    supply_guard_gate u_gate (
        .rd_allow_i(rd_allow),
        .wr_allow_i(wr_allow),
        .ce_i      (ce_i),
        .we_i      (we_i),
        .oe_i      (oe_i),
        .ce_o      (ce_o),
        .we_o      (we_o),
        .oe_o      (oe_o)
    );

    assign wp_o    = ~wr_allow;
    assign armed_o = r_q.armed;
endmodule

// File: rtl/supply_guard_chk.sv
module supply_guard_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic supply_ok_i,
    input logic ce_i,
    input logic we_i,
    input logic ce_o,
    input logic we_o,
    input logic oe_o,
    input logic wp_o,
    input logic armed_o
);
    // R2: a sampled supply loss closes the strobes within three edges
    p_fast_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !supply_ok_i |-> ##3 (!ce_o && !we_o));

    // R4: no write strobe while write protection is reported
    p_wp_blocks_we_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wp_o |-> !we_o);

    // R3: the gated chip enable never appears without a request
    p_ce_needs_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ce_o |-> ce_i);

    // R7: a write strobe needs the chip enable and a write request
    p_we_needs_ce_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we_o |-> (ce_o && we_i));

    // R7: data drive is off during a write and without chip enable
    p_oe_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        oe_o |-> (ce_o && !we_i));

    // R8: the armed flag never clears outside reset
    p_armed_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(armed_o) |-> armed_o);

    // R8: write access only after arming
    p_open_needs_arm_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wp_o |-> armed_o);
endmodule

bind supply_guard supply_guard_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .supply_ok_i(supply_ok_i),
    .ce_i       (ce_i),
    .we_i       (we_i),
    .ce_o       (ce_o),
    .we_o       (we_o),
    .oe_o       (oe_o),
    .wp_o       (wp_o),
    .armed_o    (armed_o)
);

// File: tb/supply_guard_test.sv
`timescale 1ns/1ps
module supply_guard_test;
    localparam int REC  = 12;
    localparam int HOLD = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sup = 1'b0;
    logic ce_r = 1'b0, we_r = 1'b0, oe_r = 1'b0;
    logic ce_g, we_g, oe_g, wp, armed;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;
    string cur_tag = "R1";

    always #2 clk = ~clk;

    supply_guard #(.RECOVER_CYC(REC), .HOLD_CYC(HOLD)) uut (
        .clk_i(clk), .rst_ni(rst_n), .supply_ok_i(sup),
        .ce_i(ce_r), .we_i(we_r), .oe_i(oe_r),
        .ce_o(ce_g), .we_o(we_g), .oe_o(oe_g),
        .wp_o(wp), .armed_o(armed)
    );

    // expectation model: supply seen two samples late, run = good edges in a row
    logic h0 = 1'b0, h1 = 1'b0;
    int   run = 0;
    logic arm_m = 1'b0;
    always @(posedge clk) begin
        if (!rst_n) begin
            h0 <= 1'b0; h1 <= 1'b0; run <= 0; arm_m <= 1'b0;
        end else begin
            h0 <= sup;
            h1 <= h0;
            run <= h1 ? run + 1 : 0;
            arm_m <= arm_m | h1;
        end
    end

    task automatic check(input string tag, input string what, input logic got, input logic exp);
        vectors++;
        if (got !== exp) begin
            misses++;
            $display("FAIL %s %s: got %0b expected %0b (run=%0d)", tag, what, got, exp, run);
        end
    endtask

    task automatic step(input int n, input logic s, input string tag);
        for (int i = 0; i < n; i++) begin
            logic norm, rd, e_ce, e_we, e_oe;
            @(negedge clk);
            norm = (run - 1 >= REC);
            rd   = (run >= 1) && (run - 1 >= HOLD);
            e_ce = rst_n & ce_r & rd;
            e_we = rst_n & we_r & ce_r & norm;
            e_oe = e_ce & oe_r & ~we_r;
            check(tag, "ce_o", ce_g, e_ce);
            check(run == 0 ? "R3" : (norm ? "R7" : "R4"), "we_o", we_g, e_we);
            check("R7", "oe_o", oe_g, e_oe);
            check(rst_n ? "R4" : "R1", "wp_o", wp, ~norm);
            check(rst_n ? "R8" : "R1", "armed_o", armed, arm_m);
            {ce_r, we_r, oe_r} = 3'(vectors);
            sup = s;
            cur_tag = tag;
        end
    endtask

    initial begin
        sup = 1'b1;
        step(4, 1'b1, "R1");
        @(negedge clk);
        rst_n = 1'b1;
        sup = 1'b0;
        step(6, 1'b0, "R3");
        step(30, 1'b1, "R5");
        step(6, 1'b0, "R2");
        step(8, 1'b1, "R5");
        step(4, 1'b0, "R2");
        step(30, 1'b1, "R6");
        step(1, 1'b0, "R2");
        step(30, 1'b1, "R7");
        step(5, 1'b0, "R2");
        step(8, 1'b0, "R8");
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            misses++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule